// File: doc/BRIEF.md
# Ring Oscillator Race Comparator

The block returns one bit of a physically unclonable identifier. It compares two on-die ring oscillators and reports which one is faster. An 8-bit challenge picks one oscillator out of a bank of sixteen for a "top" path and one for a "bottom" path. Each picked oscillator clocks a counter of its own. The two counters start from zero together and run toward a common terminal count. The path whose counter gets there first sets the response bit.

The counters run in the oscillator clock domains. Each terminal flag is brought into the system clock domain through a two-flop synchronizer. A controller in the system domain latches the challenge, holds the counters cleared between races, and decides the winner from the first synchronized flag it sees. When the outcome is known, `done` pulses for one cycle. `resp`, `tie` and `same_sel` then keep their values until the next accepted start.

`start` is a plain control pulse. There is no valid/ready stream at this block's edge. A start pulse is accepted only while no race is in progress. A pulse that arrives during a race is dropped, so the caller waits for `done` before issuing the next challenge.

Top module: `ro_race_puf`

## Requirements
- R1: On an accepted start, `challenge[7:4]` selects the top oscillator and `challenge[3:0]` selects the bottom oscillator (index n means `osc_in[n]`). The challenge is latched and does not change during the race.
- R2: Both counters are cleared on an accepted start and begin together. Each one counts rising edges of its selected oscillator and stops at TERM_CNT (default 1023). The race therefore lasts at least TERM_CNT periods of the faster selected oscillator.
- R3: If the top path's synchronized flag arrives first, `resp` is 1. If the bottom path's flag arrives first, `resp` is 0. In both cases `tie` is 0.
- R4: If both synchronized flags first appear in the same system clock cycle and the two selections differ, `resp` is 1 and `tie` is 1.
- R5: If both fields of the challenge name the same oscillator, the race still completes with `done`. The result is `resp` = 0, `same_sel` = 1 and `tie` = 0.
- R6: `done` is high for exactly one system clock cycle per race. A flag that arrives after the decision causes no second `done` and no change of `resp`.
- R7: `resp`, `tie` and `same_sel` hold their values from the decision until the next accepted start, which clears them to 0.
- R8: A start pulse that arrives while a race is running is ignored. The running race finishes with the result of the original challenge, and only one `done` follows.
- R9: After reset, `resp`, `done`, `tie` and `same_sel` are 0 and the block is idle, ready to accept a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 16 | Free-running oscillator bank (NUM_OSC = 2**SEL_W) |
| challenge | input | 8 | Selection pair: upper half top, lower half bottom (2*SEL_W) |
| start | input | 1 | Single-cycle request to begin a race |
| resp | output | 1 | Response bit: 1 when the top path wins |
| done | output | 1 | One-cycle pulse when the race is decided |
| tie | output | 1 | Both flags arrived in the same cycle |
| same_sel | output | 1 | Both paths selected the same oscillator |

## Verification
The assertions check on every cycle the properties that hold whatever the oscillator timing:
- `done` never lasts two cycles;
- idle outputs do not drift without a start;
- the latched challenge is frozen during a race;
- a same-oscillator result never reports 1 or a tie;
- a tie always carries `resp` = 1.

Which path wins, how long a race lasts, and whether a start issued mid-race is dropped all depend on the oscillator periods. Only the bench scenarios can show these, using oscillator periods that are known in advance.

// File: rtl/puf_race_pkg.sv
`timescale 1ns/1ps
package puf_race_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2
  } race_state_e;

  // system cycles the counters stay cleared before a race, long enough
  // to flush the two-flop synchronizers of the previous race's flags
  localparam int CLEAR_CYCLES = 3;
  localparam int CLR_CNT_W    = $clog2(CLEAR_CYCLES + 1);
endpackage

// File: rtl/puf_osc_select.sv
`timescale 1ns/1ps
module puf_osc_select #(
  parameter int SEL_W = 4,
  localparam int NUM_OSC = 1 << SEL_W
) (
  input  logic [NUM_OSC-1:0] osc_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               osc_out
);
  // select only changes while the counter it feeds is held in clear
  assign osc_out = osc_in[sel];
endmodule

// File: rtl/puf_race_counter.sv
`timescale 1ns/1ps
module puf_race_counter #(
  parameter int TERM_CNT = 1023,
  localparam int CNT_W = $clog2(TERM_CNT + 1)
) (
  input  logic osc_clk,
  input  logic clr,
  output logic at_term
);
  logic [CNT_W-1:0] cnt;

  // flag is a flop of its own so the crossing sees a glitch-free edge
  always_ff @(posedge osc_clk or posedge clr) begin
    if (clr) begin
      cnt     <= '0;
      at_term <= 1'b0;
    end else if (cnt != CNT_W'(TERM_CNT)) begin
      cnt     <= cnt + 1'b1;
      at_term <= (cnt == CNT_W'(TERM_CNT - 1));
    end
  end
endmodule

// File: rtl/puf_flag_sync.sv
`timescale 1ns/1ps
module puf_flag_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/puf_race_ctrl.sv
`timescale 1ns/1ps
module puf_race_ctrl
  import puf_race_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int CHAL_W = 2 * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAL_W-1:0] challenge,
  input  logic              top_hit,
  input  logic              bot_hit,
  output logic              clr,
  output logic [CHAL_W-1:0] chal_q,
  output logic              busy,
  output logic              resp,
  output logic              done,
  output logic              tie,
  output logic              same_sel
);
  race_state_e          state;
  logic [CLR_CNT_W-1:0] clr_cyc;
  logic                 same_now;

  assign same_now = (chal_q[CHAL_W-1:SEL_W] == chal_q[SEL_W-1:0]);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      clr      <= 1'b1;
      clr_cyc  <= '0;
      chal_q   <= '0;
      resp     <= 1'b0;
      done     <= 1'b0;
      tie      <= 1'b0;
      same_sel <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_CLEAR;
            chal_q   <= challenge;
            clr_cyc  <= '0;
            resp     <= 1'b0;
            tie      <= 1'b0;
            same_sel <= 1'b0;
          end
        end
        ST_CLEAR: begin
          clr_cyc <= clr_cyc + 1'b1;
          if (clr_cyc == CLR_CNT_W'(CLEAR_CYCLES - 1)) begin
            state <= ST_RUN;
            clr   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (top_hit || bot_hit) begin
            state <= ST_IDLE;
            clr   <= 1'b1;
            done  <= 1'b1;
            if (same_now) begin
              resp     <= 1'b0;
              tie      <= 1'b0;
              same_sel <= 1'b1;
            end else begin
              resp <= top_hit;
              tie  <= top_hit && bot_hit;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          clr   <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ro_race_puf.sv
`timescale 1ns/1ps
module ro_race_puf #(
  parameter int SEL_W    = 4,
  parameter int TERM_CNT = 1023,
  localparam int NUM_OSC = 1 << SEL_W,
  localparam int CHAL_W  = 2 * SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OSC-1:0] osc_in,
  input  logic [CHAL_W-1:0]  challenge,
  input  logic               start,
  output logic               resp,
  output logic               done,
  output logic               tie,
  output logic               same_sel
);
  logic              cnt_clr;
  logic              race_busy;
  logic [CHAL_W-1:0] chal_q;
  logic [1:0]        hit_sync;   // [1] top path, [0] bottom path

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic osc_sel;
    logic term_raw;

    puf_osc_select #(.SEL_W(SEL_W)) u_sel (
      .osc_in  (osc_in),
      .sel     (chal_q[p*SEL_W +: SEL_W]),
      .osc_out (osc_sel)
    );

    puf_race_counter #(.TERM_CNT(TERM_CNT)) u_cnt (
      .osc_clk (osc_sel),
      .clr     (cnt_clr),
      .at_term (term_raw)
    );

    puf_flag_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (term_raw),
      .q     (hit_sync[p])
    );
  end

  puf_race_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .challenge (challenge),
    .top_hit   (hit_sync[1]),
    .bot_hit   (hit_sync[0]),
    .clr       (cnt_clr),
    .chal_q    (chal_q),
    .busy      (race_busy),
    .resp      (resp),
    .done      (done),
    .tie       (tie),
    .same_sel  (same_sel)
  );
endmodule

// File: rtl/puf_race_checks.sv
`timescale 1ns/1ps
module puf_race_checks #(
  parameter int CHAL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [CHAL_W-1:0] chal_q,
  input logic              resp,
  input logic              done,
  input logic              tie,
  input logic              same_sel
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(resp) && $stable(tie) && $stable(same_sel)));

  p_chal_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chal_q));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(chal_q));

  p_same_resp0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    same_sel |-> (!resp && !tie));

  p_tie_resp1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tie |-> resp);
endmodule

bind ro_race_puf puf_race_checks #(.CHAL_W(CHAL_W)) u_race_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (race_busy),
  .chal_q   (chal_q),
  .resp     (resp),
  .done     (done),
  .tie      (tie),
  .same_sel (same_sel)
);

// File: tb/sim_ro_race_puf.sv
`timescale 1ns/1ps
module sim_ro_race_puf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] osc = '0;
  logic [7:0]  challenge = '0;
  logic        start = 1'b0;
  logic        resp, done, tie, same_sel;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  // Oscillator i has half period 5.0 + 0.04*i ns, so a lower index is faster.
  // Oscillator 15 copies oscillator 14 exactly, so the 14/15 pair always ties.
  for (genvar i = 0; i < 16; i++) begin : g_osc
    localparam real HP = 5.0 + 0.04 * ((i == 15) ? 14 : i);
    always #(HP) osc[i] = ~osc[i];
  end

  ro_race_puf u0 (
    .clk(clk), .rst_n(rst_n), .osc_in(osc), .challenge(challenge),
    .start(start), .resp(resp), .done(done), .tie(tie), .same_sel(same_sel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int idx);
    return (idx == 15) ? 14 : idx;
  endfunction

  task automatic pulse_start(input logic [7:0] chal);
    @(negedge clk);
    challenge = chal;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done, returns cycles counted from the start pulse
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic race_and_check(input logic [7:0] chal);
    int cyc;
    int t = int'(chal[7:4]);
    int b = int'(chal[3:0]);
    int er, et, es;
    es = (t == b) ? 1 : 0;
    et = (!es && eff(t) == eff(b)) ? 1 : 0;
    er = es ? 0 : (et ? 1 : ((eff(t) < eff(b)) ? 1 : 0));
    pulse_start(chal);
    wait_done(cyc);
    check(done == 1'b1, $sformatf("R6 done seen chal=%02h", chal), int'(done), 1);
    if (es == 1) begin
      check(resp == 1'b0, "R5 resp same osc", int'(resp), 0);
      check(same_sel == 1'b1, "R5 same_sel", int'(same_sel), 1);
    end else if (et == 1) begin
      check(resp == 1'b1, "R4 resp on tie", int'(resp), 1);
      check(tie == 1'b1, "R4 tie flag", int'(tie), 1);
    end else begin
      check(resp == er[0], $sformatf("R1 R3 resp chal=%02h", chal), int'(resp), er);
      check(tie == 1'b0, "R3 no tie", int'(tie), 0);
    end
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", int'(done), 0);
  endtask

  task automatic test_reset();
    check(resp == 1'b0, "R9 resp reset", int'(resp), 0);
    check(done == 1'b0, "R9 done reset", int'(done), 0);
    check(tie == 1'b0, "R9 tie reset", int'(tie), 0);
    check(same_sel == 1'b0, "R9 same_sel reset", int'(same_sel), 0);
  endtask

  task automatic test_duration();
    int cyc;
    pulse_start(8'h05);
    wait_done(cyc);
    // osc 0: 10 ns period, 1023 periods = 1279 system cycles plus clear and sync
    check(cyc >= 1279 && cyc <= 1300, "R2 race length", cyc, 1285);
    check(resp == 1'b1, "R3 top osc0 wins", int'(resp), 1);
    @(negedge clk);
  endtask

  task automatic test_hold();
    int dones = 0;
    bit moved = 0;
    logic r0 = resp;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) dones++;
      if (resp != r0) moved = 1;
    end
    check(dones == 0, "R6 no late done", dones, 0);
    check(!moved, "R7 resp holds", int'(moved), 0);
  endtask

  task automatic test_clear_on_start();
    pulse_start(8'h50);
    check(resp == 1'b0 && same_sel == 1'b0, "R7 cleared on accepted start",
          int'(resp), 0);
    begin
      int cyc;
      wait_done(cyc);
    end
    check(resp == 1'b0, "R3 bottom osc0 wins", int'(resp), 0);
    @(negedge clk);
  endtask

  task automatic test_start_during_run();
    int cyc;
    int dones = 0;
    pulse_start(8'h05);
    repeat (200) @(negedge clk);
    pulse_start(8'h50);   // must be dropped
    wait_done(cyc);
    check(resp == 1'b1, "R8 original challenge kept", int'(resp), 1);
    for (int k = 0; k < 1800; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0, "R8 only one done", dones, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_duration();
    test_hold();
    test_clear_on_start();
    race_and_check(8'h3C);
    race_and_check(8'hC3);
    race_and_check(8'h34);
    race_and_check(8'h77);
    race_and_check(8'hFE);
    race_and_check(8'hA2);
    test_start_during_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule